// File: doc/BRIEF.md
# Performance Counter Unit with Global Control

This block counts hardware events for performance analysis. It holds a parameterized set of programmable counters, each with its own event-select register, and a set of fixed-function counters. All fixed counters are configured through packed 4-bit fields in one shared control register. A global enable register gates every counter. A global status register latches a per-counter overflow flag, and a write-one-to-clear register acknowledges those flags.

Each event input is a per-cycle pulse. Whether a pulse is counted depends on several things: the counter's local configuration, its global enable, the current privilege level (`kernel_mode`), and the thread qualifier (`own_thread`). A counter whose interrupt enable is set raises `irq` when it wraps. The unit can be set to freeze every counter when that happens. Software resumes counting by clearing the frozen flag.

Registers are reached through a single-cycle write port and a read port with one cycle of latency. The register map is below. Counter index i and fixed index n are added to the base address.
- 0x00+i: programmable counter, write takes bits 31:0 sign-extended.
- 0x10+i: the same counter, full-width write alias.
- 0x20+i: event select.
- 0x30+n: fixed counter.
- 0x40: fixed control.
- 0x41: global enable.
- 0x42: global status.
- 0x43: overflow clear.
- 0x44: freeze control.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all counters, control registers, the status register and `irq` are zero.
- R2: Programmable counter i adds one per cycle in which its event is high, under four conditions. Event-select bit 4 (enable) must be set. Global enable bit i must be set. The privilege bit must match: bit 1 for kernel, bit 0 for user. The thread qualifier must pass. Clearing any of these stops the count.
- R3: Fixed counter n is set up by fixed-control bits 4n+3..4n, with bit 0 kernel, bit 1 user, bit 2 any-thread and bit 3 interrupt enable. It counts when a privilege bit matches the current mode and global enable bit 32+n is set.
- R4: A pulse is counted only when `own_thread` is 1, unless the counter's any-thread bit is set (event-select bit 2, or field bit 2 for a fixed counter).
- R5: Counter writes keep only the low CW bits. A write to a primary programmable address stores wdata[31:0] sign-extended to CW bits. A write to the alias address or to a fixed counter stores wdata[CW-1:0].
- R6: A counter holding all ones that takes an event wraps to zero and sets its status bit: bit i for a programmable counter, bit 32+n for a fixed counter. A preload of 2^CW−N therefore wraps on exactly the Nth event.
- R7: Writing a mask to 0x43 clears the matching status bits and leaves the others unchanged. An overflow in the same cycle still sets its bit.
- R8: `irq` is registered and equals the OR over counters of status bit AND that counter's interrupt enable (event-select bit 3, field bit 3). It stays high until the status bits are cleared.
- R9: With freeze-control bit 0 set, an overflow of an interrupt-enabled counter sets status bit 63 and stops all counting. Clearing bit 63 through 0x43 resumes counting.
- R10: When a register write targets a counter in the same cycle as one of its events, the written value is stored and the event is lost.
- R11: A read with `rd_en` returns the addressed register on `rdata` in the next cycle. Address 0x43 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid the cycle after `rd_en` |
| prog_evt | input | NP | Event pulses for the programmable counters |
| fix_evt | input | NF | Event pulses for the fixed counters |
| kernel_mode | input | 1 | 1 when the current privilege is kernel |
| own_thread | input | 1 | 1 when the current events belong to this thread |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two operations can land on the same counter in one cycle: a software write to the counter and an event increment. The bench drives both together: the write strobe to the alias address and the event pulse are raised on the same edge. A read-back afterwards must return exactly the written value, with no extra count. A second overlap is an overflow-clear write arriving while the freeze and status logic is active. The bench checks it by reading status and counter values before and after each clear.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // register addresses (base + index)
  localparam logic [7:0] A_PCNT   = 8'h00;
  localparam logic [7:0] A_PALIAS = 8'h10;
  localparam logic [7:0] A_PEVS   = 8'h20;
  localparam logic [7:0] A_FCNT   = 8'h30;
  localparam logic [7:0] A_FCTL   = 8'h40;
  localparam logic [7:0] A_GCTL   = 8'h41;
  localparam logic [7:0] A_GSTS   = 8'h42;
  localparam logic [7:0] A_OVCLR  = 8'h43;
  localparam logic [7:0] A_FRZ    = 8'h44;

  // event-select bits
  localparam int EVS_W   = 5;
  localparam int EVS_USR = 0;
  localparam int EVS_KRN = 1;
  localparam int EVS_ANY = 2;
  localparam int EVS_INT = 3;
  localparam int EVS_EN  = 4;

  // fixed-control field bits
  localparam int FC_W   = 4;
  localparam int FC_KRN = 0;
  localparam int FC_USR = 1;
  localparam int FC_ANY = 2;
  localparam int FC_INT = 3;

  localparam int FIX_BASE   = 32;
  localparam int FROZEN_BIT = 63;

  function automatic logic [63:0] sext32(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction
endpackage

// File: rtl/pmu_gate.sv
module pmu_gate (
  input  logic evt,
  input  logic loc_en,
  input  logic glob_en,
  input  logic frozen,
  input  logic kmode,
  input  logic krn_ok,
  input  logic usr_ok,
  input  logic any_ok,
  input  logic own_thread,
  output logic inc
);
  logic priv_ok;
  logic thr_ok;

  always_comb begin
    priv_ok = (kmode & krn_ok) | (~kmode & usr_ok);
    thr_ok  = own_thread | any_ok;
    inc     = evt & loc_en & glob_en & ~frozen & priv_ok & thr_ok;
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          wr,
  input  logic [CW-1:0] wval,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  // a write always wins over an increment in the same cycle
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (wr)  cnt <= wval;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign wrap = inc & ~wr & (&cnt);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int NP = 4,
  parameter int NF = 3,
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    addr,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata,
  input  logic [NP-1:0] prog_evt,
  input  logic [NF-1:0] fix_evt,
  input  logic          kernel_mode,
  input  logic          own_thread,
  output logic          irq
);
  import pmu_pkg::*;

  localparam int FCW = FC_W * NF;

  logic [NP-1:0][EVS_W-1:0] evs_q, evs_n;
  logic [FCW-1:0]           fc_q, fc_n;
  logic [63:0]              gc_q, gc_n, gc_mask;
  logic [63:0]              st_q, st_n;
  logic                     frz_en_q, frz_en_n;
  logic [63:0]              ie_q, ie_n, ovf, clr;
  logic                     irq_n;
  logic [63:0]              rd_mux;

  logic [NP-1:0][CW-1:0] p_cnt;
  logic [NF-1:0][CW-1:0] f_cnt;
  logic [NP-1:0]         p_inc, p_wr, p_wrap;
  logic [NF-1:0]         f_inc, f_wr, f_wrap;
  logic [NP-1:0][CW-1:0] p_wval;

  // ---------------- counters ----------------
  for (genvar i = 0; i < NP; i++) begin : g_prog
    logic wr_pri, wr_ali;
    assign wr_pri    = wr_en && (addr == 8'(A_PCNT + i));
    assign wr_ali    = wr_en && (addr == 8'(A_PALIAS + i));
    assign p_wr[i]   = wr_pri | wr_ali;
    assign p_wval[i] = wr_ali ? wdata[CW-1:0] : CW'(sext32(wdata));

    pmu_gate u_gate (
      .evt        (prog_evt[i]),
      .loc_en     (evs_q[i][EVS_EN]),
      .glob_en    (gc_q[i]),
      .frozen     (st_q[FROZEN_BIT]),
      .kmode      (kernel_mode),
      .krn_ok     (evs_q[i][EVS_KRN]),
      .usr_ok     (evs_q[i][EVS_USR]),
      .any_ok     (evs_q[i][EVS_ANY]),
      .own_thread (own_thread),
      .inc        (p_inc[i])
    );

    pmu_counter #(.CW(CW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .inc  (p_inc[i]),
      .wr   (p_wr[i]),
      .wval (p_wval[i]),
      .cnt  (p_cnt[i]),
      .wrap (p_wrap[i])
    );
  end

  for (genvar n = 0; n < NF; n++) begin : g_fix
    logic [FC_W-1:0] fld;
    assign fld     = fc_q[FC_W*n +: FC_W];
    assign f_wr[n] = wr_en && (addr == 8'(A_FCNT + n));

    pmu_gate u_gate (
      .evt        (fix_evt[n]),
      .loc_en     (fld[FC_KRN] | fld[FC_USR]),
      .glob_en    (gc_q[FIX_BASE + n]),
      .frozen     (st_q[FROZEN_BIT]),
      .kmode      (kernel_mode),
      .krn_ok     (fld[FC_KRN]),
      .usr_ok     (fld[FC_USR]),
      .any_ok     (fld[FC_ANY]),
      .own_thread (own_thread),
      .inc        (f_inc[n])
    );

    pmu_counter #(.CW(CW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .inc  (f_inc[n]),
      .wr   (f_wr[n]),
      .wval (wdata[CW-1:0]),
      .cnt  (f_cnt[n]),
      .wrap (f_wrap[n])
    );
  end

  // ---------------- control next state ----------------
  always_comb begin
    gc_mask = '0;
    for (int i = 0; i < NP; i++) gc_mask[i] = 1'b1;
    for (int n = 0; n < NF; n++) gc_mask[FIX_BASE + n] = 1'b1;

    evs_n    = evs_q;
    fc_n     = fc_q;
    gc_n     = gc_q;
    frz_en_n = frz_en_q;
    if (wr_en) begin
      for (int i = 0; i < NP; i++)
        if (addr == 8'(A_PEVS + i)) evs_n[i] = wdata[EVS_W-1:0];
      if (addr == A_FCTL) fc_n     = wdata[FCW-1:0];
      if (addr == A_GCTL) gc_n     = wdata & gc_mask;
      if (addr == A_FRZ)  frz_en_n = wdata[0];
    end
  end

  // interrupt-enable vector aligned to status bits
  always_comb begin
    ie_q = '0;
    ie_n = '0;
    for (int i = 0; i < NP; i++) begin
      ie_q[i] = evs_q[i][EVS_INT];
      ie_n[i] = evs_n[i][EVS_INT];
    end
    for (int n = 0; n < NF; n++) begin
      ie_q[FIX_BASE + n] = fc_q[FC_W*n + FC_INT];
      ie_n[FIX_BASE + n] = fc_n[FC_W*n + FC_INT];
    end
  end

  // status: overflow sets win over a same-cycle clear
  always_comb begin
    ovf = '0;
    for (int i = 0; i < NP; i++) ovf[i] = p_wrap[i];
    for (int n = 0; n < NF; n++) ovf[FIX_BASE + n] = f_wrap[n];
    clr  = (wr_en && addr == A_OVCLR) ? wdata : '0;
    st_n = (st_q & ~clr) | ovf;
    st_n[FROZEN_BIT] = (st_q[FROZEN_BIT] & ~clr[FROZEN_BIT]) |
                       (frz_en_q & (|(ovf & ie_q)));
    irq_n = |(st_n[62:0] & ie_n[62:0]);
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NP; i++) begin
      if (addr == 8'(A_PCNT + i) || addr == 8'(A_PALIAS + i)) rd_mux = 64'(p_cnt[i]);
      if (addr == 8'(A_PEVS + i)) rd_mux = 64'(evs_q[i]);
    end
    for (int n = 0; n < NF; n++)
      if (addr == 8'(A_FCNT + n)) rd_mux = 64'(f_cnt[n]);
    case (addr)
      A_FCTL:  rd_mux = 64'(fc_q);
      A_GCTL:  rd_mux = gc_q;
      A_GSTS:  rd_mux = st_q;
      A_FRZ:   rd_mux = 64'(frz_en_q);
      default: ;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      evs_q    <= '0;
      fc_q     <= '0;
      gc_q     <= '0;
      st_q     <= '0;
      frz_en_q <= 1'b0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      evs_q    <= evs_n;
      fc_q     <= fc_n;
      gc_q     <= gc_n;
      st_q     <= st_n;
      frz_en_q <= frz_en_n;
      irq      <= irq_n;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk #(
  parameter int NP = 4,
  parameter int NF = 3,
  parameter int CW = 48
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [7:0]                    addr,
  input logic [63:0]                   wdata,
  input logic                          irq,
  input logic [63:0]                   st_q,
  input logic [63:0]                   gc_q,
  input logic [NP-1:0][pmu_pkg::EVS_W-1:0] evs_q,
  input logic [pmu_pkg::FC_W*NF-1:0]   fc_q,
  input logic [NP-1:0][CW-1:0]         p_cnt,
  input logic [NF-1:0][CW-1:0]         f_cnt
);
  import pmu_pkg::*;

  logic [62:0] ie_chk;
  always_comb begin
    ie_chk = '0;
    for (int i = 0; i < NP; i++) ie_chk[i] = evs_q[i][EVS_INT];
    for (int n = 0; n < NF; n++) ie_chk[FIX_BASE + n] = fc_q[FC_W*n + FC_INT];
  end

  // R8: request follows enabled status bits
  a_r8_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == (|(st_q[62:0] & ie_chk))));

  for (genvar i = 0; i < NP; i++) begin : g_pa
    logic cw;
    assign cw = wr_en && (addr == 8'(A_PCNT + i) || addr == 8'(A_PALIAS + i));

    // R2: global enable off means the counter holds
    a_r2_global_off_holds: assert property (@(posedge clk) disable iff (rst)
      (!gc_q[i] && !cw) |=> $stable(p_cnt[i]));

    // R9: frozen means the counter holds
    a_r9_frozen_holds: assert property (@(posedge clk) disable iff (rst)
      (st_q[FROZEN_BIT] && !cw) |=> $stable(p_cnt[i]));

    // R6: wrap to zero is reflected in status
    a_r6_wrap_sets_status: assert property (@(posedge clk) disable iff (rst)
      ((&p_cnt[i]) && !cw) |=> (p_cnt[i] != '0 || st_q[i]));

    // R10: alias write lands regardless of events
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == 8'(A_PALIAS + i)) |=> (p_cnt[i] == $past(wdata[CW-1:0])));
  end

  for (genvar n = 0; n < NF; n++) begin : g_fa
    logic cw;
    assign cw = wr_en && (addr == 8'(A_FCNT + n));

    // R9: fixed counters also hold while frozen
    a_r9_fixed_frozen_holds: assert property (@(posedge clk) disable iff (rst)
      (st_q[FROZEN_BIT] && !cw) |=> $stable(f_cnt[n]));
  end
endmodule

bind perf_mon_unit perf_mon_unit_chk #(.NP(NP), .NF(NF), .CW(CW)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .irq   (irq),
  .st_q  (st_q),
  .gc_q  (gc_q),
  .evs_q (evs_q),
  .fc_q  (fc_q),
  .p_cnt (p_cnt),
  .f_cnt (f_cnt)
);

// File: tb/perf_mon_unit_tb_top.sv
`timescale 1ns/1ps
module perf_mon_unit_tb_top;
  localparam int NP = 4;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [NP-1:0] prog_evt = '0;
  logic [NF-1:0] fix_evt = '0;
  logic          kernel_mode = 1'b1, own_thread = 1'b1;
  logic          irq;

  int checks = 0, errors = 0;
  logic [63:0] v;

  always #5 clk = ~clk;

  perf_mon_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .prog_evt(prog_evt), .fix_evt(fix_evt),
    .kernel_mode(kernel_mode), .own_thread(own_thread), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 events
    logic [7:0]  a;    // events: {1'b0, fixed mask[2:0], prog mask[3:0]}
    logic [63:0] d;    // events: cycle count
    logic [63:0] e;
  } vec_t;

  localparam vec_t TBL [20] = '{
    '{2'd0, 8'h20, 64'h12, 64'h0},            // R2 enable + kernel
    '{2'd0, 8'h41, 64'h1_0000_0001, 64'h0},
    '{2'd0, 8'h40, 64'h1, 64'h0},             // R3 fixed0 kernel
    '{2'd2, 8'h11, 64'd5, 64'h0},
    '{2'd1, 8'h00, 64'h0, 64'd5},             // R2
    '{2'd1, 8'h30, 64'h0, 64'd5},             // R3
    '{2'd0, 8'h41, 64'h1, 64'h0},
    '{2'd2, 8'h11, 64'd3, 64'h0},
    '{2'd1, 8'h00, 64'h0, 64'd8},             // R2
    '{2'd1, 8'h30, 64'h0, 64'd5},             // R3 global bit off
    '{2'd0, 8'h20, 64'h11, 64'h0},
    '{2'd2, 8'h01, 64'd2, 64'h0},
    '{2'd1, 8'h00, 64'h0, 64'd8},             // R2 privilege mismatch
    '{2'd0, 8'h00, 64'h0000_0000_8000_0000, 64'h0},
    '{2'd1, 8'h00, 64'h0, 64'h0000_FFFF_8000_0000}, // R5 sign extend
    '{2'd0, 8'h10, 64'hFFFF_1234_5678_9ABC, 64'h0},
    '{2'd1, 8'h00, 64'h0, 64'h0000_1234_5678_9ABC}, // R5 alias
    '{2'd1, 8'h43, 64'h0, 64'h0},             // R11
    '{2'd1, 8'h20, 64'h0, 64'h11},            // R11
    '{2'd1, 8'h41, 64'h0, 64'h1}              // R11
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] r);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; r = rdata;
  endtask

  task automatic pulse(input logic [NP-1:0] pm, input logic [NF-1:0] fm, input int n);
    @(negedge clk); prog_evt = pm; fix_evt = fm;
    repeat (n) @(negedge clk);
    prog_evt = '0; fix_evt = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 64'(irq), 64'h0);
    rd(8'h42, v); chk("R1 status", v, 64'h0);
    rd(8'h00, v); chk("R1 counter", v, 64'h0);
    rd(8'h41, v); chk("R1 global", v, 64'h0);

    foreach (TBL[k]) begin
      case (TBL[k].op)
        2'd0: wr(TBL[k].a, TBL[k].d);
        2'd1: begin
          rd(TBL[k].a, v);
          chk($sformatf("table[%0d] addr %h", k, TBL[k].a), v, TBL[k].e);
        end
        default: pulse(TBL[k].a[3:0], TBL[k].a[6:4], int'(TBL[k].d));
      endcase
    end

    // R5 fixed counter truncation
    wr(8'h30, 64'hABCD_0000_0000_0005);
    rd(8'h30, v); chk("R5 fixed trunc", v, 64'h5);

    // R4 thread qualifier
    wr(8'h21, 64'h12); wr(8'h41, 64'h3);
    own_thread = 1'b0;
    pulse(4'b0010, 3'b000, 3);
    rd(8'h01, v); chk("R4 other thread blocked", v, 64'd0);
    wr(8'h21, 64'h16);
    pulse(4'b0010, 3'b000, 3);
    rd(8'h01, v); chk("R4 any-thread counts", v, 64'd3);
    own_thread = 1'b1;

    // R6 / R8 sampling preload of three events
    wr(8'h21, 64'h1A);
    wr(8'h11, 64'h0000_FFFF_FFFF_FFFD);
    pulse(4'b0010, 3'b000, 2);
    rd(8'h42, v); chk("R6 no wrap after two", v, 64'h0);
    chk("R8 irq low", 64'(irq), 64'h0);
    pulse(4'b0010, 3'b000, 1);
    rd(8'h42, v); chk("R6 wrap on third", v, 64'h2);
    rd(8'h01, v); chk("R6 counter wrapped", v, 64'h0);
    chk("R8 irq high", 64'(irq), 64'h1);
    rd(8'h42, v); chk("R8 status held", v, 64'h2);

    // R7 clear
    wr(8'h43, 64'h2);
    rd(8'h42, v); chk("R7 cleared", v, 64'h0);
    chk("R7 irq dropped", 64'(irq), 64'h0);

    // R8 overflow without interrupt enable
    wr(8'h22, 64'h12); wr(8'h12, 64'h0000_FFFF_FFFF_FFFF); wr(8'h41, 64'h7);
    pulse(4'b0100, 3'b000, 1);
    rd(8'h42, v); chk("R8 status no ie", v, 64'h4);
    chk("R8 irq stays low", 64'(irq), 64'h0);
    wr(8'h43, 64'h4);

    // R9 freeze on interrupt
    wr(8'h44, 64'h1);
    wr(8'h40, 64'h90);
    wr(8'h31, 64'h0000_FFFF_FFFF_FFFF);
    wr(8'h20, 64'h12);
    wr(8'h10, 64'd10);
    wr(8'h41, 64'h2_0000_0001);
    pulse(4'b0001, 3'b010, 1);
    rd(8'h42, v); chk("R9 frozen flag", v, 64'h8000_0002_0000_0000);
    chk("R9 irq", 64'(irq), 64'h1);
    pulse(4'b0001, 3'b000, 4);
    rd(8'h00, v); chk("R9 no count while frozen", v, 64'd11);
    wr(8'h43, 64'h8000_0002_0000_0000);
    pulse(4'b0001, 3'b000, 2);
    rd(8'h00, v); chk("R9 resumes", v, 64'd13);
    rd(8'h42, v); chk("R9 status clear", v, 64'h0);

    // R10 write and event in the same cycle
    @(negedge clk); wr_en = 1'b1; addr = 8'h10; wdata = 64'd100; prog_evt = 4'b0001;
    @(negedge clk); wr_en = 1'b0; prog_evt = '0;
    rd(8'h00, v); chk("R10 write wins", v, 64'd100);

    finish_run();
  end
endmodule